// File: doc/BRIEF.md
# Debounced Input Edge Interrupt

This block watches six board-level inputs: a power button, three keyboard lines, an AC-present indication and the reset line coming back from the embedded controller. For each input, software decides whether a change from high to low, a change from low to high, or both should be reported. A change is reported only after the new level has held for a programmable number of cycles, so contact bounce and short glitches are filtered out. Each reported change sets a sticky status bit that names the input and the direction. All status bits together drive one interrupt line.

A second path gives software the pin levels as they are. The raw pins pass through a two-stage synchronizer and appear on a readback port. This path bypasses the optional per-input inversion, which only affects how edges are classified.

No data stream passes through the block, so every pin is a plain control or status signal. The clear strobe is accepted on every cycle and never stalls.

Top module: `dbedge_irq`

## Requirements
- R1: While reset is held and right after it is released, `status_o` is all zero, `irq_o` is low and `raw_o` is all zero.
- R2: An edge sets its status bit only if that input's enable for that direction (`fall_en_i` for high-to-low, `rise_en_i` for low-to-high) is set in the cycle the edge is accepted. A disabled direction leaves the status unchanged.
- R3: Let D be the value of `debounce_i`. A change that stays put is accepted once the new synchronized level has been seen on D+1 consecutive clock edges. Its status bit becomes visible after the (D+3)th rising edge, counting the first edge that samples the changed pin as edge 1, and not earlier.
- R4: A pulse that lasts D clock cycles or fewer sets no status bit, in either direction. Any return to the accepted level restarts the count.
- R5: Status bit i reports a high-to-low edge of input i, and bit 6+i reports a low-to-high edge of input i. The inputs are numbered 0 power button, 1 to 3 keys 0 to 2, 4 AC present, 5 controller reset.
- R6: A cycle with `clr_valid_i` high clears every status bit whose `clr_mask_i` bit is 1 (write-1-to-clear), and the other bits are kept. If a bit is set by an edge and cleared in the same cycle, the bit ends up set.
- R7: `irq_o` is high exactly when at least one status bit is set, and it changes in the same cycle as the status.
- R8: `raw_o` equals `pins_i` delayed by two clock edges, and `invert_i` has no effect on it.
- R9: Edges are classified on `pins_i` XOR `invert_i`. With the inversion bit set, a rising pin is reported as a high-to-low edge.
- R10: The level present when the block leaves reset is taken as the starting level, and no edge is reported for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | 6 | Raw asynchronous input pins |
| invert_i | input | 6 | Per-input polarity inversion applied before edge detection |
| fall_en_i | input | 6 | High-to-low edge enables |
| rise_en_i | input | 6 | Low-to-high edge enables |
| debounce_i | input | 16 | Debounce length D, in cycles |
| clr_valid_i | input | 1 | Clear strobe |
| clr_mask_i | input | 12 | Status bits to clear when the strobe is high |
| status_o | output | 12 | Sticky edge status, falls in bits 5:0, rises in bits 11:6 |
| irq_o | output | 1 | Combined interrupt |
| raw_o | output | 6 | Synchronized raw pin levels |

## Verification
Each input's filter keeps an accepted level and a counter, and neither can be seen directly. If the accepted level is wrong, the next genuine change raises the wrong direction bit or no bit at all, which shows one settle window (D+3 edges) after the stimulus. If the counter is wrong, the status bit rises a cycle early or late against the exact edge count in R3, or a pulse one cycle too short still sets a bit. A wrong synchronizer or warm-up appears within three edges of reset as a `raw_o` mismatch or as a bit set for the starting level.

// File: rtl/dbedge_pkg.sv
package dbedge_pkg;

  // Number of monitored inputs: power button, three keys, AC present, controller reset.
  localparam int NUM_IN = 6;

  // Per-input edge event pair produced by a filter lane.
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_evt_t;

endpackage

// File: rtl/dbedge_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
module dbedge_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/dbedge_filter.sv
// One debounce lane: holds the accepted level and counts how long a
// different level has persisted. Emits a one-cycle event when it commits.
module dbedge_filter #(
  parameter int DB_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ready_i,   // synchronizer pipeline holds real data
  input  logic                  lvl_i,     // synchronized, polarity-adjusted level
  input  logic [DB_W-1:0]       limit_i,   // debounce length D
  output dbedge_pkg::edge_evt_t evt_o
);

  logic            primed_q;
  logic            stable_q;
  logic [DB_W-1:0] cnt_q;
  logic            differ;
  logic            commit;

  always_comb begin
    differ     = (lvl_i != stable_q);
    // >= keeps the lane from stalling if the limit is lowered mid-count
    commit     = primed_q && differ && (cnt_q >= limit_i);
    evt_o.rise = commit &  lvl_i;
    evt_o.fall = commit & ~lvl_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q <= 1'b0;
      stable_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!primed_q) begin
      // first valid sample becomes the starting level, no event
      if (ready_i) begin
        primed_q <= 1'b1;
        stable_q <= lvl_i;
        cnt_q    <= '0;
      end
    end else if (!differ) begin
      cnt_q <= '0;
    end else if (commit) begin
      stable_q <= lvl_i;
      cnt_q    <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/dbedge_status.sv
// Sticky write-1-to-clear status with a combined interrupt.
module dbedge_status #(
  parameter int N_ST = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_ST-1:0] set_i,
  input  logic            clr_valid_i,
  input  logic [N_ST-1:0] clr_mask_i,
  output logic [N_ST-1:0] status_o,
  output logic            irq_o
);

  logic [N_ST-1:0] status_q;
  logic [N_ST-1:0] clr_eff;

  always_comb begin
    clr_eff = clr_valid_i ? clr_mask_i : {N_ST{1'b0}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_eff) | set_i;  // set wins
  end

  assign status_o = status_q;
  assign irq_o    = |status_q;

endmodule

// File: rtl/dbedge_irq.sv
// Debounced edge interrupt for six board inputs with raw pin readback.
module dbedge_irq #(
  parameter int N_IN        = dbedge_pkg::NUM_IN,
  parameter int DB_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_IN-1:0]     pins_i,
  input  logic [N_IN-1:0]     invert_i,
  input  logic [N_IN-1:0]     fall_en_i,
  input  logic [N_IN-1:0]     rise_en_i,
  input  logic [DB_W-1:0]     debounce_i,
  input  logic                clr_valid_i,
  input  logic [2*N_IN-1:0]   clr_mask_i,
  output logic [2*N_IN-1:0]   status_o,
  output logic                irq_o,
  output logic [N_IN-1:0]     raw_o
);

  localparam int N_ST = 2 * N_IN;

  logic [N_IN-1:0]        sync_lvl;
  logic [N_IN-1:0]        det_lvl;
  logic [SYNC_STAGES-1:0] fill_q;
  logic                   sync_ready;
  logic [N_ST-1:0]        set_vec;
  dbedge_pkg::edge_evt_t  evt [N_IN];

  dbedge_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_i),
    .q_o    (sync_lvl)
  );

  // Tracks when the synchronizer output first carries sampled pin data.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fill_q <= '0;
    else         fill_q <= {fill_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign sync_ready = fill_q[SYNC_STAGES-1];

  assign raw_o   = sync_lvl;
  assign det_lvl = sync_lvl ^ invert_i;

  for (genvar i = 0; i < N_IN; i++) begin : g_lane
    dbedge_filter #(.DB_W(DB_W)) u_filter (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ready_i (sync_ready),
      .lvl_i   (det_lvl[i]),
      .limit_i (debounce_i),
      .evt_o   (evt[i])
    );
    assign set_vec[i]      = evt[i].fall & fall_en_i[i];
    assign set_vec[N_IN+i] = evt[i].rise & rise_en_i[i];
  end

  dbedge_status #(.N_ST(N_ST)) u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (set_vec),
    .clr_valid_i (clr_valid_i),
    .clr_mask_i  (clr_mask_i),
    .status_o    (status_o),
    .irq_o       (irq_o)
  );

endmodule

// File: rtl/dbedge_irq_chk.sv
// Port-level properties of dbedge_irq, attached with bind below.
module dbedge_irq_chk #(
  parameter int N_IN = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_IN-1:0]   pins_i,
  input logic [N_IN-1:0]   invert_i,
  input logic [N_IN-1:0]   fall_en_i,
  input logic [N_IN-1:0]   rise_en_i,
  input logic              clr_valid_i,
  input logic [2*N_IN-1:0] clr_mask_i,
  input logic [2*N_IN-1:0] status_o,
  input logic [N_IN-1:0]   raw_o
);

  localparam int N_ST = 2 * N_IN;

  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  AST_RAW_TWO_EDGE_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) |-> (raw_o == $past(pins_i, 2)));  // R8

  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((($past(status_o) & ~($past(clr_valid_i) ? $past(clr_mask_i) : {N_ST{1'b0}}))
      & ~status_o) == {N_ST{1'b0}}));  // R6

  AST_SET_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o & ~$past(status_o) & ~$past({rise_en_i, fall_en_i})) == {N_ST{1'b0}}));  // R2

  AST_FALL_AT_LOW_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o[N_IN-1:0] & ~$past(status_o[N_IN-1:0]) & $past(raw_o ^ invert_i))
      == {N_IN{1'b0}}));  // R9

  AST_RISE_AT_HIGH_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o[N_ST-1:N_IN] & ~$past(status_o[N_ST-1:N_IN]) & ~$past(raw_o ^ invert_i))
      == {N_IN{1'b0}}));  // R9

endmodule

bind dbedge_irq dbedge_irq_chk #(.N_IN(N_IN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pins_i      (pins_i),
  .invert_i    (invert_i),
  .fall_en_i   (fall_en_i),
  .rise_en_i   (rise_en_i),
  .clr_valid_i (clr_valid_i),
  .clr_mask_i  (clr_mask_i),
  .status_o    (status_o),
  .raw_o       (raw_o)
);

// File: tb/dbedge_irq_tb.sv
`timescale 1ns/1ps
module dbedge_irq_tb;

  localparam int N = 6;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  pins = '0;
  logic [N-1:0]  invert = '0;
  logic [N-1:0]  fall_en = '0;
  logic [N-1:0]  rise_en = '0;
  logic [15:0]   debounce = '0;
  logic          clr_valid = 1'b0;
  logic [2*N-1:0] clr_mask = '0;
  logic [2*N-1:0] status;
  logic          irq;
  logic [N-1:0]  raw;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  dbedge_irq u_dut (
    .clk_i (clk), .rst_ni (rst_ni), .pins_i (pins), .invert_i (invert),
    .fall_en_i (fall_en), .rise_en_i (rise_en), .debounce_i (debounce),
    .clr_valid_i (clr_valid), .clr_mask_i (clr_mask),
    .status_o (status), .irq_o (irq), .raw_o (raw)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    clr_valid = 1'b1; clr_mask = '1;
    tick(1);
    clr_valid = 1'b0; clr_mask = '0;
  endtask

  // Expected status after a pulse of L cycles away from a settled level (R3, R4, R5).
  function automatic logic [2*N-1:0] exp_status(input int idx, input int L, input int D,
                                                input bit enf, input bit enr);
    logic [2*N-1:0] e = '0;
    if (L >= D + 1) begin
      e[idx]   = enf;
      e[N+idx] = enr;
    end
    return e;
  endfunction

  task automatic run_trial(input int idx, input bit b, input int L, input int D,
                           input bit inv, input bit enf, input bit enr, input string req);
    logic [2*N-1:0] e;
    fall_en = '0; rise_en = '0;
    debounce = 16'(D);
    invert[idx] = inv;
    pins[idx] = b;
    tick(D + 8);
    clear_all();
    fall_en[idx] = enf; rise_en[idx] = enr;
    tick(1);
    pins[idx] = ~b;
    tick(L);
    pins[idx] = b;
    tick(D + 8);
    e = exp_status(idx, L, D, enf, enr);
    check(status == e, req, 32'(status), 32'(e));
    check(irq == (e != '0), {req, " R7 irq"}, 32'(irq), 32'(e != '0));
    fall_en = '0; rise_en = '0;
    clear_all();
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    // R10: power button held high through reset, everything enabled, D=0
    pins = 6'b000001; fall_en = '1; rise_en = '1; debounce = 16'd0;
    tick(4);
    check(status == '0 && irq == 1'b0, "R1 status/irq in reset", 32'(status), 32'h0);
    rst_ni = 1'b1;
    check(raw == '0, "R1 raw after release", 32'(raw), 32'h0);
    check(status == '0, "R1 status after release", 32'(status), 32'h0);
    tick(10);
    check(status == '0, "R10 starting level not reported", 32'(status), 32'h0);
    check(raw == pins, "R8 raw follows pins", 32'(raw), 32'(pins));
    fall_en = '0; rise_en = '0; pins = '0;
    tick(10);
    clear_all();

    // R3 timing and R8 latency: key0 (input 1) rising, D=3
    debounce = 16'd3; rise_en[1] = 1'b1;
    tick(2);
    pins[1] = 1'b1;
    tick(1);
    check(raw[1] == 1'b0, "R8 raw after one edge", 32'(raw[1]), 32'h0);
    tick(1);
    check(raw[1] == 1'b1, "R8 raw after two edges", 32'(raw[1]), 32'h1);
    tick(3);
    check(status == '0, "R3 not before edge D+3", 32'(status), 32'h0);
    tick(1);
    check(status == 12'h080, "R3 R5 rise bit of key0 at edge D+3", 32'(status), 32'h080);
    check(irq == 1'b1, "R7 irq with status set", 32'(irq), 32'h1);

    // R6 clearing other bits keeps this one, then clearing it drops irq
    clr_valid = 1'b1; clr_mask = 12'hF7F;
    tick(1);
    clr_valid = 1'b0;
    check(status == 12'h080, "R6 unmasked bit kept", 32'(status), 32'h080);
    clr_valid = 1'b1; clr_mask = 12'h080;
    tick(1);
    clr_valid = 1'b0; clr_mask = '0;
    check(status == '0, "R6 w1c clears bit", 32'(status), 32'h0);
    check(irq == 1'b0, "R7 irq low when empty", 32'(irq), 32'h0);
    rise_en = '0;

    // R6 set and clear in the same cycle: key1 (input 2) falling, D=2
    debounce = 16'd2;
    pins[2] = 1'b1;
    tick(10);
    clear_all();
    fall_en[2] = 1'b1;
    tick(1);
    pins[2] = 1'b0;
    tick(4);
    clr_valid = 1'b1; clr_mask = '1;
    tick(1);
    clr_valid = 1'b0; clr_mask = '0;
    check(status == 12'h004, "R6 set wins over clear", 32'(status), 32'h004);
    fall_en = '0;
    clear_all();

    // R9 inversion: AC present (input 4) rising pin with invert reports a fall
    debounce = 16'd1; invert[4] = 1'b1;
    tick(8);
    clear_all();
    fall_en[4] = 1'b1; rise_en[4] = 1'b1;
    tick(1);
    pins[4] = 1'b1;
    tick(8);
    check(status == 12'h010, "R9 inverted rise reported as fall", 32'(status), 32'h010);
    check(raw[4] == 1'b1, "R8 raw ignores inversion", 32'(raw[4]), 32'h1);
    fall_en = '0; rise_en = '0;
    clear_all();

    // R4 glitch boundary on controller reset input (5), D=4
    run_trial(5, 1'b0, 4, 4, 1'b0, 1'b1, 1'b1, "R4 pulse of D cycles ignored");
    run_trial(5, 1'b0, 5, 4, 1'b0, 1'b1, 1'b1, "R4 pulse of D+1 cycles reported");
    // R2 single direction enabled
    run_trial(0, 1'b1, 6, 2, 1'b0, 1'b1, 1'b0, "R2 fall only enabled");
    run_trial(3, 1'b0, 6, 2, 1'b0, 1'b0, 1'b0, "R2 nothing enabled");

    // Random trials covering R2 R3 R4 R5 R9
    for (int t = 0; t < 40; t++) begin
      int idx = int'($urandom_range(0, N-1));
      int dd  = int'($urandom_range(0, 5));
      int ll  = int'($urandom_range(1, 8));
      run_trial(idx, 1'($urandom), ll, dd, 1'($urandom), 1'($urandom), 1'($urandom),
                "R2 R3 R4 R5 random trial");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule